// File: doc/BRIEF.md
# Buffer-Ready Status and Interrupt Unit

This unit keeps one buffer-ready status bit for each pipe of a USB function or host controller and merges the enabled bits into a single interrupt request for the CPU. The FIFO and transfer logic feed it per-pipe single-cycle events and levels. The events are: buffer-ready, end-of-transfer packet received, buffer fully read, zero-length packet into an empty buffer, CPU-side zero-length acknowledge and buffer clear. The levels are buffer writable and buffer readable. Software reads the bits and clears them by writing zeros. A write of one leaves that pipe alone, so one pipe can be acknowledged without a read-modify-write race against the others.

There are three status modes. In packet mode, every buffer-ready event sets the bit. In transfer-end mode, which is chosen per pipe and only has an effect on receive pipes, the bit is set only once the CPU has drained the last data of a complete transfer. In mirror mode, which is global and meant for a level-type interrupt line with transfer-end mode off on every pipe, each bit simply follows the buffer state. All status bits are registered and change one clock after the event that moves them. The interrupt is a combinational OR of the status bits ANDed with their enables.

Top module: `brdy_status_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every status bit is 0 and `irq` is 0.
- R2: In packet mode (`mirror_mode`=0 and the pipe's `end_mode` bit 0), a pulse on a pipe's `ev_ready` sets that pipe's status bit on the next clock.
- R3: Outside mirror mode, a write with `wr_en`=1 clears every pipe whose `wr_data` bit is 0 and leaves every pipe whose bit is 1 unchanged.
- R4: When a set event and a write of 0 hit the same pipe in the same cycle, the bit ends up at 1.
- R5: In transfer-end mode on a receive pipe (`dir_tx`=0), the bit is set by a `buf_drained` pulse only when an `rx_last` pulse came in an earlier cycle since the last set or clear. `buf_drained` alone and `ev_ready` never set it.
- R6: In transfer-end mode, a transmit pipe (`dir_tx`=1) never sets its bit, whatever events arrive.
- R7: In transfer-end mode, an `rx_zlp_empty` pulse followed later by `zlp_ack` sets the bit. The pipe then ignores further end-of-transfer events until `buf_clr`.
- R8: In mirror mode (`mirror_mode`=1), one clock after the inputs change, a transmit pipe's bit equals `buf_writable` and a receive pipe's bit equals `buf_readable`.
- R9: In mirror mode, software writes of 0 have no effect on the status bits.
- R10: In mirror mode, the bit of pipe 0 (the control pipe) in the transmit direction stays 0 even while its buffer is writable.
- R11: In mirror mode, an `rx_zlp_empty` pulse on a receive pipe holds its bit at 1, even with `buf_readable` at 0 and after `zlp_ack`, until a `buf_clr` pulse for that pipe.
- R12: Outside mirror mode, `buf_clr` clears the pipe's bit on the next clock and takes priority over a simultaneous set event.
- R13: `irq` is 1 exactly when some pipe has both its status bit and its `irq_en` bit at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mirror_mode | input | 1 | Global mirror mode select |
| end_mode | input | NPIPE | Per-pipe transfer-end mode select |
| dir_tx | input | NPIPE | Per-pipe direction, 1 = transmit |
| irq_en | input | NPIPE | Per-pipe interrupt enable |
| ev_ready | input | NPIPE | Buffer-ready event pulse (packet mode) |
| buf_writable | input | NPIPE | Level: buffer can accept CPU writes |
| buf_readable | input | NPIPE | Level: buffer holds data for the CPU |
| rx_last | input | NPIPE | Pulse: end-of-transfer packet received (short, zero-length or counter terminal) |
| buf_drained | input | NPIPE | Pulse: CPU has read all data in the buffer |
| rx_zlp_empty | input | NPIPE | Pulse: zero-length packet received into an empty buffer |
| zlp_ack | input | NPIPE | Pulse: CPU-side acknowledge of that zero-length packet |
| buf_clr | input | NPIPE | Pulse: buffer-clear command |
| wr_en | input | 1 | Status register write strobe |
| wr_data | input | NPIPE | Write data, 0 clears, 1 keeps |
| status | output | NPIPE | Status bits |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench sweeps every pipe in turn in each mode. It targets the corners where a faulty unit is visible at the ports. A unit that treats a written 1 as a clear would wipe unrelated pipes. If the clear wins over a simultaneous set, an event is lost. Transfer-end mode is probed with a drain that has no end packet before it, which must not raise the bit, and with transmit pipes, which must stay silent. It also checks that further events are refused after a zero-length acknowledge, which a unit without the parked state would accept. In mirror mode the bench checks that writes of 0 are ignored, that the control pipe's transmit bit is masked, and that the zero-length hold persists through the acknowledge and drops only on buffer clear.

// File: rtl/brdy_pkg.sv
// Package: shared types for the buffer-ready status unit.
// Assumes nothing beyond IEEE 1800-2017 enums.
package brdy_pkg;
    typedef enum logic [1:0] {
        MODE_PACKET  = 2'd0,
        MODE_XFEREND = 2'd1,
        MODE_MIRROR  = 2'd2
    } brdy_mode_e;
endpackage

// File: rtl/brdy_mode_sel.sv
// Module: brdy_mode_sel
// Resolves the effective status mode of each pipe from the global mirror
// bit and the per-pipe transfer-end bits. Mirror mode overrides every pipe.
// Assumes configuration is quasi-static during a transfer.
module brdy_mode_sel
    import brdy_pkg::*;
#(
    parameter int NPIPE = 10
) (
    input  logic             mirror_mode,
    input  logic [NPIPE-1:0] end_mode,
    output brdy_mode_e       mode_o [NPIPE]
);
    for (genvar i = 0; i < NPIPE; i++) begin : g_mode
        // Priority: mirror, then transfer-end, then per-packet.
        always_comb begin
            if (mirror_mode)      mode_o[i] = MODE_MIRROR;
            else if (end_mode[i]) mode_o[i] = MODE_XFEREND;
            else                  mode_o[i] = MODE_PACKET;
        end
    end
endmodule

// File: rtl/brdy_pipe_cell.sv
// Module: brdy_pipe_cell
// One pipe's status bit with the set and clear rules of all three modes,
// plus the pipe's end-of-transfer and zero-length tracking flags.
// Assumes input events are single-cycle pulses from the FIFO logic.
module brdy_pipe_cell
    import brdy_pkg::*;
#(
    parameter int PIPE_IDX = 0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  brdy_mode_e mode,
    input  logic       dir_tx,
    input  logic       ev_ready,
    input  logic       buf_writable,
    input  logic       buf_readable,
    input  logic       rx_last,
    input  logic       buf_drained,
    input  logic       rx_zlp_empty,
    input  logic       zlp_ack,
    input  logic       buf_clr,
    input  logic       wr_zero,
    output logic       status
);
    localparam bit IS_CTRL = (PIPE_IDX == 0);

    logic armed_q, armed_d;
    logic zwait_q, zwait_d;
    logic zhold_q, zhold_d;
    logic status_q, status_d;
    logic end_rx, parked, done_set;

    // Transfer-end tracking for receive pipes.
    always_comb begin
        end_rx   = (mode == MODE_XFEREND) && !dir_tx;
        parked   = zhold_q && !zwait_q;
        done_set = end_rx && !parked &&
                   ((armed_q && buf_drained) || (zwait_q && zlp_ack));
    end

    // Next state of the tracking flags.
    always_comb begin
        zhold_d = buf_clr ? 1'b0 : (rx_zlp_empty || zhold_q);
        if (buf_clr)           zwait_d = 1'b0;
        else if (rx_zlp_empty) zwait_d = 1'b1;
        else if (zlp_ack)      zwait_d = 1'b0;
        else                   zwait_d = zwait_q;
        if (buf_clr)                armed_d = 1'b0;
        else if (rx_last && end_rx) armed_d = 1'b1;
        else if (done_set)          armed_d = 1'b0;
        else                        armed_d = armed_q;
    end

    // Next status bit per mode; set beats software clear, buffer clear beats both.
    always_comb begin
        unique case (mode)
            MODE_MIRROR: begin
                if (dir_tx) status_d = buf_writable && !IS_CTRL;
                else        status_d = buf_readable || zhold_d;
            end
            MODE_XFEREND: begin
                if (buf_clr)       status_d = 1'b0;
                else if (done_set) status_d = 1'b1;
                else if (wr_zero)  status_d = 1'b0;
                else               status_d = status_q;
            end
            default: begin
                if (buf_clr)       status_d = 1'b0;
                else if (ev_ready) status_d = 1'b1;
                else if (wr_zero)  status_d = 1'b0;
                else               status_d = status_q;
            end
        endcase
    end

    // State registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q  <= 1'b0;
            zwait_q  <= 1'b0;
            zhold_q  <= 1'b0;
            status_q <= 1'b0;
        end else begin
            armed_q  <= armed_d;
            zwait_q  <= zwait_d;
            zhold_q  <= zhold_d;
            status_q <= status_d;
        end
    end

    assign status = status_q;

    // R3: a written 1 with no other event keeps a set bit.
    p_wr_one_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_PACKET && status_q && !wr_zero && !buf_clr) |=> status_q);

    // R6: transmit pipes in transfer-end mode stay clear.
    p_tx_end_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_XFEREND && dir_tx && !status_q) |=> !status_q);

    // R8: mirror of a writable transmit buffer.
    p_mirror_tx_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_MIRROR && dir_tx && buf_writable && !IS_CTRL) |=> status_q);

    // R11: zero-length hold persists until buffer clear.
    p_zlp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_MIRROR && !dir_tx && rx_zlp_empty && !buf_clr) |=> status_q);

    // R12: buffer clear wins outside mirror mode.
    p_clr_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_MIRROR && buf_clr) |=> !status_q);

    // R4: set event beats a simultaneous write of 0.
    p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_PACKET && ev_ready && wr_zero && !buf_clr) |=> status_q);

    if (IS_CTRL) begin : g_ctrl_chk
        // R10: control pipe transmit bit masked in mirror mode.
        p_ctrl_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (mode == MODE_MIRROR && dir_tx) |=> !status_q);
    end
endmodule

// File: rtl/brdy_irq_merge.sv
// Module: brdy_irq_merge
// Combines enabled status bits into one interrupt request.
// Assumes a level-sensitive consumer.
module brdy_irq_merge #(
    parameter int NPIPE = 10
) (
    input  logic [NPIPE-1:0] status,
    input  logic [NPIPE-1:0] irq_en,
    output logic             irq
);
    // OR-reduce of enabled bits.
    always_comb irq = |(status & irq_en);
endmodule

// File: rtl/brdy_status_ctrl.sv
// Module: brdy_status_ctrl
// Top of the buffer-ready status unit: decodes software writes, resolves
// per-pipe modes, holds one status cell per pipe and merges the interrupt.
// Assumes all inputs are synchronous to clk.
module brdy_status_ctrl
    import brdy_pkg::*;
#(
    parameter int NPIPE = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mirror_mode,
    input  logic [NPIPE-1:0] end_mode,
    input  logic [NPIPE-1:0] dir_tx,
    input  logic [NPIPE-1:0] irq_en,
    input  logic [NPIPE-1:0] ev_ready,
    input  logic [NPIPE-1:0] buf_writable,
    input  logic [NPIPE-1:0] buf_readable,
    input  logic [NPIPE-1:0] rx_last,
    input  logic [NPIPE-1:0] buf_drained,
    input  logic [NPIPE-1:0] rx_zlp_empty,
    input  logic [NPIPE-1:0] zlp_ack,
    input  logic [NPIPE-1:0] buf_clr,
    input  logic             wr_en,
    input  logic [NPIPE-1:0] wr_data,
    output logic [NPIPE-1:0] status,
    output logic             irq
);
    brdy_mode_e       pipe_mode [NPIPE];
    logic [NPIPE-1:0] wr_zero;

    // Write decode: a 0 in the data clears that pipe.
    always_comb wr_zero = wr_en ? ~wr_data : '0;

    brdy_mode_sel #(.NPIPE(NPIPE)) u_mode (
        .mirror_mode (mirror_mode),
        .end_mode    (end_mode),
        .mode_o      (pipe_mode)
    );

    for (genvar i = 0; i < NPIPE; i++) begin : g_pipe
        brdy_pipe_cell #(.PIPE_IDX(i)) u_cell (
            .clk          (clk),
            .rst_n        (rst_n),
            .mode         (pipe_mode[i]),
            .dir_tx       (dir_tx[i]),
            .ev_ready     (ev_ready[i]),
            .buf_writable (buf_writable[i]),
            .buf_readable (buf_readable[i]),
            .rx_last      (rx_last[i]),
            .buf_drained  (buf_drained[i]),
            .rx_zlp_empty (rx_zlp_empty[i]),
            .zlp_ack      (zlp_ack[i]),
            .buf_clr      (buf_clr[i]),
            .wr_zero      (wr_zero[i]),
            .status       (status[i])
        );
    end

    brdy_irq_merge #(.NPIPE(NPIPE)) u_irq (
        .status (status),
        .irq_en (irq_en),
        .irq    (irq)
    );

    // R13: a quiet request line means no enabled bit is set.
    p_irq_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> ((status & irq_en) == '0));

    // R9: in mirror mode a write of zeros with steady levels changes nothing.
    p_mirror_wr_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mirror_mode && $past(mirror_mode) && wr_en && $stable(buf_writable) &&
         $stable(buf_readable) && $stable(dir_tx) && rx_zlp_empty == '0 &&
         buf_clr == '0) |=> $stable(status));
endmodule

// File: tb/sim_brdy_status_ctrl.sv
`timescale 1ns/1ps
module sim_brdy_status_ctrl;
    localparam int NP = 10;
    localparam logic [NP-1:0] ALL = '1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mirror_mode = 1'b0;
    logic [NP-1:0] end_mode = '0, dir_tx = '0, irq_en = '0, ev_ready = '0;
    logic [NP-1:0] buf_writable = '0, buf_readable = '0, rx_last = '0;
    logic [NP-1:0] buf_drained = '0, rx_zlp_empty = '0, zlp_ack = '0, buf_clr = '0;
    logic wr_en = 1'b0;
    logic [NP-1:0] wr_data = '0;
    logic [NP-1:0] status;
    logic irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    brdy_status_ctrl #(.NPIPE(NP)) u0 (
        .clk(clk), .rst_n(rst_n), .mirror_mode(mirror_mode), .end_mode(end_mode),
        .dir_tx(dir_tx), .irq_en(irq_en), .ev_ready(ev_ready),
        .buf_writable(buf_writable), .buf_readable(buf_readable),
        .rx_last(rx_last), .buf_drained(buf_drained), .rx_zlp_empty(rx_zlp_empty),
        .zlp_ack(zlp_ack), .buf_clr(buf_clr), .wr_en(wr_en), .wr_data(wr_data),
        .status(status), .irq(irq)
    );

    task automatic chk(string tag, logic [NP-1:0] act, logic [NP-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // One clock: inputs driven at a negedge are sampled here at the next negedge.
    task automatic tick();
        @(negedge clk);
    endtask

    task automatic clear_pulses();
        ev_ready = '0; rx_last = '0; buf_drained = '0; rx_zlp_empty = '0;
        zlp_ack = '0; buf_clr = '0; wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic pulse_clr(logic [NP-1:0] m);
        buf_clr = m; tick(); clear_pulses();
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [NP-1:0] exp;
        @(negedge clk);
        tick(); tick();
        chk("R1 status after reset", status, '0);
        chk("R1 irq after reset", {{(NP-1){1'b0}}, irq}, '0);
        rst_n = 1'b1;
        tick();

        // R2: packet-mode set, one pipe at a time.
        exp = '0;
        for (int i = 0; i < NP; i++) begin
            ev_ready = NP'(1) << i; tick(); clear_pulses();
            exp[i] = 1'b1;
            chk("R2 packet set", status, exp);
        end
        // R3: writing all ones keeps everything.
        wr_en = 1'b1; wr_data = ALL; tick(); clear_pulses();
        chk("R3 write ones keeps", status, ALL);
        // R3: write 0 to one pipe at a time.
        for (int i = 0; i < NP; i++) begin
            wr_en = 1'b1; wr_data = ~(NP'(1) << i); tick(); clear_pulses();
            exp[i] = 1'b0;
            chk("R3 write zero clears one", status, exp);
        end
        // R4: set and clear-write collide.
        ev_ready = ALL; wr_en = 1'b1; wr_data = '0; tick(); clear_pulses();
        chk("R4 set beats write zero", status, ALL);
        // R13: irq per enable.
        for (int i = 0; i < NP; i++) begin
            irq_en = NP'(1) << i; #1;
            chk("R13 irq single enable", {{(NP-1){1'b0}}, irq}, NP'(1));
        end
        wr_en = 1'b1; wr_data = 10'b0101010101; tick(); clear_pulses();
        chk("R3 pattern clear", status, 10'b0101010101);
        irq_en = 10'b1010101010; #1;
        chk("R13 irq masked off", {{(NP-1){1'b0}}, irq}, '0);
        irq_en = 10'b0000000100; #1;
        chk("R13 irq one hit", {{(NP-1){1'b0}}, irq}, NP'(1));
        irq_en = '0;
        // R12: clear beats simultaneous set.
        ev_ready = ALL; buf_clr = ALL; tick(); clear_pulses();
        chk("R12 clear beats set", status, '0);
        ev_ready = ALL; tick(); clear_pulses();
        pulse_clr(ALL);
        chk("R12 clear", status, '0);

        // Transfer-end mode, receive pipes.
        end_mode = ALL; dir_tx = '0;
        buf_drained = ALL; ev_ready = ALL; tick(); clear_pulses();
        chk("R5 drain without end packet", status, '0);
        exp = '0;
        for (int i = 0; i < NP; i++) begin
            rx_last = NP'(1) << i; tick(); clear_pulses();
            chk("R5 end packet alone", status, exp);
            buf_drained = NP'(1) << i; tick(); clear_pulses();
            exp[i] = 1'b1;
            chk("R5 drain after end packet", status, exp);
        end
        pulse_clr(ALL);
        // R6: transmit pipes never set.
        dir_tx = ALL;
        rx_last = ALL; ev_ready = ALL; tick(); clear_pulses();
        buf_drained = ALL; rx_zlp_empty = ALL; tick(); clear_pulses();
        zlp_ack = ALL; tick(); clear_pulses();
        chk("R6 tx silent in transfer-end", status, '0);
        pulse_clr(ALL);
        // R7: zero-length into empty buffer.
        dir_tx = '0;
        for (int i = 0; i < NP; i++) begin
            rx_zlp_empty = NP'(1) << i; tick(); clear_pulses();
            chk("R7 zlp before ack", status, '0);
            zlp_ack = NP'(1) << i; tick(); clear_pulses();
            chk("R7 set on ack", status, NP'(1) << i);
            wr_en = 1'b1; wr_data = '0; tick(); clear_pulses();
            rx_last = NP'(1) << i; tick(); clear_pulses();
            buf_drained = NP'(1) << i; tick(); clear_pulses();
            chk("R7 parked ignores end", status, '0);
            pulse_clr(NP'(1) << i);
            rx_last = NP'(1) << i; tick(); clear_pulses();
            buf_drained = NP'(1) << i; tick(); clear_pulses();
            chk("R7 resumes after clear", status, NP'(1) << i);
            pulse_clr(ALL);
        end

        // Mirror mode.
        end_mode = '0; mirror_mode = 1'b1; dir_tx = ALL;
        for (int p = 0; p < 8; p++) begin
            logic [NP-1:0] pat;
            pat = NP'(p * 149 + 3) ^ (NP'(p) << 5);
            buf_writable = pat; tick();
            chk("R8 R10 mirror tx", status, pat & ~NP'(1));
        end
        buf_writable = ALL; tick();
        chk("R10 control pipe masked", status, ALL & ~NP'(1));
        buf_writable = '0;
        dir_tx = '0;
        for (int p = 0; p < 8; p++) begin
            logic [NP-1:0] pat;
            pat = NP'(p * 211 + 1) ^ (NP'(p) << 3);
            buf_readable = pat; tick();
            chk("R8 mirror rx", status, pat);
        end
        buf_readable = 10'b1100110011; tick();
        wr_en = 1'b1; wr_data = '0; tick(); clear_pulses();
        chk("R9 mirror ignores write", status, 10'b1100110011);
        buf_readable = '0; tick();
        chk("R8 mirror rx drained", status, '0);
        // R11: zero-length hold.
        for (int i = 0; i < NP; i++) begin
            rx_zlp_empty = NP'(1) << i; tick(); clear_pulses();
            chk("R11 zlp hold set", status, NP'(1) << i);
            zlp_ack = NP'(1) << i; tick(); clear_pulses();
            wr_en = 1'b1; wr_data = '0; tick(); clear_pulses();
            chk("R11 hold through ack", status, NP'(1) << i);
            pulse_clr(NP'(1) << i);
            chk("R11 released by clear", status, '0);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule